// File: doc/BRIEF.md
# Oversampling Serial Receiver with Error-Tagged FIFO and Idle Timeout

This block is the receive half of an asynchronous serial port. It runs on the system clock. A one-cycle enable marks ticks at sixteen times the bit rate, and the block uses those ticks to watch the serial line. When the line goes low, the block waits half a bit period and looks at the line again. A glitch that has already returned high is dropped at that point. If the start bit is confirmed, the block samples each data bit, the optional parity bit and the stop bit in the middle of its bit period.

Each assembled character is stored in a 128-entry FIFO. It is stored together with three error tags: parity error, framing error and break. The host reads characters from the head of the FIFO. The status bits always describe the character currently at the head.

Two interrupts are provided, both gated by a single receive interrupt enable. The data interrupt is raised either on the first stored character or once the fill reaches a programmed level. The timeout interrupt is raised when characters wait in the FIFO and the line has been quiet for four word lengths plus twelve bit times.

Top module: `serial_rx_core`

## Requirements
- R1: While idle, a low line seen on a tick starts a start-bit check. The line is sampled again 8 ticks later. If it is high then, the receiver returns to idle and stores no character.
- R2: Data bits arrive LSB first and are each sampled 16 ticks after the previous sample. `cfg_wlen` selects the word length: 0 gives 5 bits, 1 gives 6, 2 gives 7 and 3 gives 8. Unused upper bits of `rd_data` read as 0.
- R3: When `cfg_par_en` is 1, one parity bit follows the data. The parity is even when `cfg_par_odd` is 0 and odd when it is 1. A mismatch tags the character with a parity error, shown in `lsr[2]`.
- R4: A low stop bit tags the character with a framing error, shown in `lsr[3]`. If the data bits, the parity bit (when enabled) and the stop bit are all low, the character is also tagged as a break, shown in `lsr[4]`. After a low stop bit the receiver waits for the line to return high before it looks for a new start bit, so a long break stores exactly one character.
- R5: Characters are stored in arrival order, up to 128 of them. `rd_data` shows the head character and `rx_fill` shows the count. `lsr[0]` is 1 exactly when the FIFO is not empty. A one-cycle `rd_en` removes the head character. `rd_en` has no effect when the FIFO is empty.
- R6: `lsr[4:2]` always describes the current head character, and reads 0 when the FIFO is empty. After a read, these bits describe the new head character in the very next cycle.
- R7: If a character completes while the FIFO holds 128 characters and no read happens in that cycle, the character is discarded and `lsr[1]` (overrun) is set. Any `rd_en` clears `lsr[1]`.
- R8: `irq_rx_data` is 1 only when `cfg_rx_ien` is 1. When `cfg_trig_mode` is 0, it is raised when at least one character is stored. When `cfg_trig_mode` is 1, it is raised when the fill is at least `cfg_trig_lvl`, with a minimum of one character.
- R9: `irq_rx_tmo` is raised when `cfg_rx_ien` is 1, the FIFO is not empty, and 16*(4*(5+`cfg_wlen`)+12) ticks pass with no character completing and no read. A completing character or a read restarts the count. An empty FIFO clears the timeout.
- R10: When a character completes in the same cycle as a read, both take effect. The count is unchanged and no character is lost or reordered.
- R11: After reset the FIFO is empty, `lsr` is 0 and both interrupts are 0.

Port widths below use the default parameters: FIFO depth 128, which gives an 8-bit count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| tick16 | input | 1 | One-cycle enable at 16x the bit rate |
| rxd | input | 1 | Serial input line, idle high |
| cfg_wlen | input | 2 | Word length select (5 to 8 data bits) |
| cfg_par_en | input | 1 | Parity bit present |
| cfg_par_odd | input | 1 | 1 selects odd parity, 0 selects even parity |
| cfg_trig_mode | input | 1 | 0: data interrupt per character; 1: data interrupt at trigger level |
| cfg_trig_lvl | input | 8 | Fill level for the data interrupt in trigger mode |
| cfg_rx_ien | input | 1 | Receive interrupt enable |
| rd_en | input | 1 | Host read of the head character |
| rd_data | output | 8 | Head character |
| lsr | output | 5 | Status: [0] data ready, [1] overrun, [2] parity, [3] framing, [4] break |
| rx_fill | output | 8 | Number of stored characters |
| irq_rx_data | output | 1 | Data-ready interrupt |
| irq_rx_tmo | output | 1 | Character timeout interrupt |

## Verification
The risky coincidence is a character completing in the very cycle that the host removes the head. In that cycle the count, the write slot and the head register must all update together. The bench provokes this by loading forty characters and then asserting `rd_en` on every cycle of the next frame's stop bit, so the stop-bit sample is certain to land on a read cycle. It then checks the order of the popped characters, the resulting fill and the tag-free head. Other checks pair the timeout restart with a read, and an arrival into a full FIFO with the overrun flag.

// File: rtl/srx_pkg.sv
package srx_pkg;

  typedef struct packed {
    logic       brk;
    logic       fe;
    logic       pe;
    logic [7:0] data;
  } srx_word_t;

  typedef enum logic [2:0] {
    S_IDLE,
    S_START,
    S_DATA,
    S_PAR,
    S_STOP,
    S_WAITHI
  } srx_state_t;

endpackage

// File: rtl/srx_sampler.sv
module srx_sampler
  import srx_pkg::*;
#(
  parameter int OSR = 16
) (
  input  logic      clk,
  input  logic      rst,
  input  logic      tick,
  input  logic      rxd,
  input  logic [1:0] cfg_wlen,
  input  logic      cfg_par_en,
  input  logic      cfg_par_odd,
  output logic      push,
  output srx_word_t word
);
  localparam int CW   = $clog2(OSR);
  localparam int HALF = OSR / 2;

  srx_state_t state;
  logic [CW-1:0] cnt;
  logic [2:0]    bitn;
  logic [7:0]    sh;
  logic          par_bit;
  logic          rx_meta, rx_s;
  logic [3:0]    nbits;
  logic [7:0]    data_al;
  logic          last_tick;

  assign nbits     = {2'b00, cfg_wlen} + 4'd5;
  assign data_al   = sh >> (4'd3 - {2'b00, cfg_wlen});
  assign last_tick = (cnt == CW'(OSR - 1));

  always_ff @(posedge clk) begin
    if (rst) begin
      rx_meta <= 1'b1;
      rx_s    <= 1'b1;
    end else begin
      rx_meta <= rxd;
      rx_s    <= rx_meta;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state   <= S_IDLE;
      cnt     <= '0;
      bitn    <= '0;
      sh      <= '0;
      par_bit <= 1'b0;
      push    <= 1'b0;
      word    <= '0;
    end else begin
      push <= 1'b0;
      if (tick) begin
        case (state)
          S_IDLE: begin
            if (!rx_s) begin
              state <= S_START;
              cnt   <= '0;
            end
          end
          S_START: begin
            if (cnt == CW'(HALF - 1)) begin
              cnt  <= '0;
              bitn <= '0;
              state <= rx_s ? S_IDLE : S_DATA;
            end else begin
              cnt <= cnt + 1'b1;
            end
          end
          S_DATA: begin
            if (last_tick) begin
              cnt <= '0;
              sh  <= {rx_s, sh[7:1]};
              if ({1'b0, bitn} == nbits - 4'd1) begin
                state <= cfg_par_en ? S_PAR : S_STOP;
              end else begin
                bitn <= bitn + 1'b1;
              end
            end else begin
              cnt <= cnt + 1'b1;
            end
          end
          S_PAR: begin
            if (last_tick) begin
              cnt     <= '0;
              par_bit <= rx_s;
              state   <= S_STOP;
            end else begin
              cnt <= cnt + 1'b1;
            end
          end
          S_STOP: begin
            if (last_tick) begin
              cnt       <= '0;
              push      <= 1'b1;
              word.data <= data_al;
              word.pe   <= cfg_par_en & ((^data_al) ^ par_bit ^ cfg_par_odd);
              word.fe   <= ~rx_s;
              word.brk  <= ~rx_s & (data_al == 8'd0) & ~(cfg_par_en & par_bit);
              state     <= rx_s ? S_IDLE : S_WAITHI;
            end else begin
              cnt <= cnt + 1'b1;
            end
          end
          S_WAITHI: begin
            if (rx_s) state <= S_IDLE;
          end
          default: state <= S_IDLE;
        endcase
      end
    end
  end

  // R4: a completed character produces exactly one store pulse
  a_r4_single_push: assert property (@(posedge clk) disable iff (rst)
    push |=> !push);

  // R1: a character is only stored after a tick
  a_r1_push_on_tick: assert property (@(posedge clk) disable iff (rst)
    push |-> $past(tick));

endmodule

// File: rtl/srx_fifo.sv
module srx_fifo #(
  parameter int DEPTH = 128,
  parameter int W     = 11,
  localparam int AW   = $clog2(DEPTH),
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          push,
  input  logic [W-1:0]  wdata,
  input  logic          pop,
  output logic [W-1:0]  head,
  output logic [CW-1:0] count,
  output logic          dropped,
  output logic          popped
);
  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wptr, rptr, rptr_nx;
  logic [W-1:0]  rd_q, byp_data;
  logic          byp_q;
  logic          do_push, do_pop, full;

  function automatic logic [AW-1:0] inc(input logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  assign full    = (count == CW'(DEPTH));
  assign do_pop  = pop && (count != '0);
  assign do_push = push && (!full || do_pop);
  assign rptr_nx = do_pop ? inc(rptr) : rptr;
  assign dropped = push && !do_push;
  assign popped  = do_pop;
  assign head    = byp_q ? byp_data : rd_q;

  // storage with a registered read port
  always_ff @(posedge clk) begin
    if (do_push) mem[wptr] <= wdata;
    rd_q <= mem[rptr_nx];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wptr     <= '0;
      rptr     <= '0;
      count    <= '0;
      byp_q    <= 1'b0;
      byp_data <= '0;
    end else begin
      rptr     <= rptr_nx;
      byp_q    <= do_push && (wptr == rptr_nx);
      byp_data <= wdata;
      if (do_push) wptr <= inc(wptr);
      case ({do_push, do_pop})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
    end
  end

  a_r5_fill_bound: assert property (@(posedge clk) disable iff (rst)
    count <= CW'(DEPTH));

  a_r7_full_holds: assert property (@(posedge clk) disable iff (rst)
    (push && full && !pop) |=> (count == CW'(DEPTH)));

  a_r10_push_pop_keep: assert property (@(posedge clk) disable iff (rst)
    (push && pop && count != '0) |=> $stable(count));

endmodule

// File: rtl/srx_timeout.sv
module srx_timeout #(
  parameter int OSR = 16,
  localparam int TW = $clog2(OSR * 44 + 1)
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       tick,
  input  logic       restart,
  input  logic       active,
  input  logic [1:0] cfg_wlen,
  output logic       expired
);
  logic [TW-1:0] cnt, limit;

  // four word lengths plus twelve bit times, in ticks
  assign limit = TW'(OSR * (4 * (5 + int'(cfg_wlen)) + 12));

  always_ff @(posedge clk) begin
    if (rst || restart || !active) begin
      cnt     <= '0;
      expired <= 1'b0;
    end else if (tick && !expired) begin
      if (cnt == limit - TW'(1)) expired <= 1'b1;
      else                       cnt     <= cnt + 1'b1;
    end
  end

  a_r9_restart_clears: assert property (@(posedge clk) disable iff (rst)
    restart |=> !expired);

endmodule

// File: rtl/serial_rx_core.sv
module serial_rx_core
  import srx_pkg::*;
#(
  parameter int DEPTH = 128,
  parameter int OSR   = 16,
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          tick16,
  input  logic          rxd,
  input  logic [1:0]    cfg_wlen,
  input  logic          cfg_par_en,
  input  logic          cfg_par_odd,
  input  logic          cfg_trig_mode,
  input  logic [CW-1:0] cfg_trig_lvl,
  input  logic          cfg_rx_ien,
  input  logic          rd_en,
  output logic [7:0]    rd_data,
  output logic [4:0]    lsr,
  output logic [CW-1:0] rx_fill,
  output logic          irq_rx_data,
  output logic          irq_rx_tmo
);
  srx_word_t rx_word, head_w;
  logic      push_w, dropped, popped, tmo_exp, nonempty, lvl_hit;
  logic      ovr_q, irq_d_q, irq_t_q;

  srx_sampler #(.OSR(OSR)) u_sampler (
    .clk(clk), .rst(rst), .tick(tick16), .rxd(rxd),
    .cfg_wlen(cfg_wlen), .cfg_par_en(cfg_par_en), .cfg_par_odd(cfg_par_odd),
    .push(push_w), .word(rx_word)
  );

  srx_fifo #(.DEPTH(DEPTH), .W($bits(srx_word_t))) u_fifo (
    .clk(clk), .rst(rst), .push(push_w), .wdata(rx_word), .pop(rd_en),
    .head(head_w), .count(rx_fill), .dropped(dropped), .popped(popped)
  );

  srx_timeout #(.OSR(OSR)) u_timeout (
    .clk(clk), .rst(rst), .tick(tick16), .restart(push_w | popped),
    .active(nonempty), .cfg_wlen(cfg_wlen), .expired(tmo_exp)
  );

  assign nonempty = (rx_fill != '0);
  assign lvl_hit  = nonempty && (!cfg_trig_mode || rx_fill >= cfg_trig_lvl);

  always_ff @(posedge clk) begin
    if (rst) begin
      ovr_q   <= 1'b0;
      irq_d_q <= 1'b0;
      irq_t_q <= 1'b0;
    end else begin
      if (dropped)    ovr_q <= 1'b1;
      else if (rd_en) ovr_q <= 1'b0;
      irq_d_q <= cfg_rx_ien & lvl_hit;
      irq_t_q <= cfg_rx_ien & tmo_exp & nonempty;
    end
  end

  assign rd_data     = head_w.data;
  assign lsr         = {head_w.brk & nonempty, head_w.fe & nonempty,
                        head_w.pe & nonempty, ovr_q, nonempty};
  assign irq_rx_data = irq_d_q;
  assign irq_rx_tmo  = irq_t_q;

  a_r8_irq_gated: assert property (@(posedge clk) disable iff (rst)
    irq_rx_data |-> $past(cfg_rx_ien));

  a_r9_tmo_needs_data: assert property (@(posedge clk) disable iff (rst)
    irq_rx_tmo |-> $past(rx_fill != '0));

  a_r7_overrun_cause: assert property (@(posedge clk) disable iff (rst)
    $rose(lsr[1]) |-> $past(push_w && rx_fill == CW'(DEPTH) && !rd_en));

  a_r6_tags_need_data: assert property (@(posedge clk) disable iff (rst)
    (lsr[4:2] != 3'b000) |-> lsr[0]);

endmodule

// File: tb/test_serial_rx_core.sv
module test_serial_rx_core;
  localparam int BIT = 32;  // 16 ticks, one tick every 2 clocks

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       tick16 = 1'b0;
  logic       rxd = 1'b1;
  logic [1:0] cfg_wlen = 2'd3;
  logic       cfg_par_en = 1'b0, cfg_par_odd = 1'b0;
  logic       cfg_trig_mode = 1'b0;
  logic [7:0] cfg_trig_lvl = 8'd1;
  logic       cfg_rx_ien = 1'b0;
  logic       rd_en = 1'b0;
  logic [7:0] rd_data;
  logic [4:0] lsr;
  logic [7:0] rx_fill;
  logic       irq_rx_data, irq_rx_tmo;

  int checks = 0, fails = 0;
  bit done = 0;
  logic [7:0] popped [BIT];

  serial_rx_core i_serial_rx_core (
    .clk(clk), .rst(rst), .tick16(tick16), .rxd(rxd),
    .cfg_wlen(cfg_wlen), .cfg_par_en(cfg_par_en), .cfg_par_odd(cfg_par_odd),
    .cfg_trig_mode(cfg_trig_mode), .cfg_trig_lvl(cfg_trig_lvl),
    .cfg_rx_ien(cfg_rx_ien), .rd_en(rd_en), .rd_data(rd_data), .lsr(lsr),
    .rx_fill(rx_fill), .irq_rx_data(irq_rx_data), .irq_rx_tmo(irq_rx_tmo)
  );

  always #2 clk = ~clk;

  initial forever begin
    @(negedge clk);
    tick16 = ~tick16;
  end

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic hold(input logic v, input int n);
    @(negedge clk);
    rxd = v;
    repeat (n - 1) @(negedge clk);
  endtask

  // frame: start, nb data bits LSB first, optional parity, stop, idle
  task automatic send(input logic [7:0] d, input int nb, input bit pflip,
                      input logic stopv, input int extra_low, input bit pop_stop);
    logic p;
    p = (^(d & (8'hFF >> (8 - nb)))) ^ cfg_par_odd ^ pflip;
    hold(1'b0, BIT);
    for (int i = 0; i < nb; i++) hold(d[i], BIT);
    if (cfg_par_en) hold(p, BIT);
    if (pop_stop) begin
      for (int k = 0; k < BIT; k++) begin
        @(negedge clk);
        rxd = stopv;
        popped[k] = rd_data;
        rd_en = 1'b1;
      end
      @(negedge clk);
      rd_en = 1'b0;
    end else begin
      hold(stopv, BIT);
    end
    if (extra_low > 0) hold(1'b0, extra_low);
    hold(1'b1, BIT);
  endtask

  task automatic pop();
    @(negedge clk);
    rd_en = 1'b1;
    @(negedge clk);
    rd_en = 1'b0;
  endtask

  task automatic t_reset();
    check("R11 lsr", lsr, 0);
    check("R11 fill", rx_fill, 0);
    check("R11 irqs", {irq_rx_data, irq_rx_tmo}, 0);
  endtask

  task automatic t_basic();
    cfg_wlen = 2'd3;
    send(8'hA5, 8, 0, 1, 0, 0);
    check("R2 8-bit data", rd_data, 8'hA5);
    check("R5 fill one", rx_fill, 1);
    check("R5 lsr clean", lsr, 5'b00001);
    pop();
    check("R5 fill after read", rx_fill, 0);
    check("R5 lsr empty", lsr, 0);
    pop();
    check("R5 read on empty ignored", rx_fill, 0);
  endtask

  task automatic t_wlen();
    cfg_wlen = 2'd0;
    send(8'hF5, 5, 0, 1, 0, 0);
    check("R2 5-bit word", rd_data, 8'h15);
    pop();
    cfg_wlen = 2'd2;
    send(8'hD5, 7, 0, 1, 0, 0);
    check("R2 7-bit word", rd_data, 8'h55);
    pop();
    cfg_wlen = 2'd1;
    send(8'h2A, 6, 0, 1, 0, 0);
    check("R2 6-bit word", rd_data, 8'h2A);
    pop();
    cfg_wlen = 2'd3;
  endtask

  task automatic t_false_start();
    hold(1'b0, 6);
    hold(1'b1, 3 * BIT);
    check("R1 false start stores nothing", rx_fill, 0);
    send(8'h3C, 8, 0, 1, 0, 0);
    check("R1 next frame still received", rd_data, 8'h3C);
    pop();
  endtask

  task automatic t_parity();
    cfg_par_en = 1'b1;
    cfg_par_odd = 1'b0;
    send(8'h03, 8, 0, 1, 0, 0);
    send(8'h03, 8, 1, 1, 0, 0);
    cfg_par_odd = 1'b1;
    send(8'h01, 8, 0, 1, 0, 0);
    check("R3 even good no pe", lsr, 5'b00001);
    pop();
    check("R6 head tag bad parity", lsr, 5'b00101);
    check("R3 data kept", rd_data, 8'h03);
    pop();
    check("R3 odd good no pe", lsr, 5'b00001);
    pop();
    cfg_par_en = 1'b0;
    cfg_par_odd = 1'b0;
  endtask

  task automatic t_frame_break();
    send(8'h81, 8, 0, 0, 0, 0);
    send(8'h00, 8, 0, 0, 3 * BIT, 0);
    check("R4 long break stores one", rx_fill, 2);
    check("R4 framing only", lsr, 5'b01001);
    pop();
    check("R4 break tag", lsr, 5'b11001);
    check("R4 break data", rd_data, 0);
    pop();
    check("R6 tags clear when empty", lsr, 0);
  endtask

  task automatic t_trigger();
    cfg_wlen = 2'd0;
    cfg_rx_ien = 1'b1;
    cfg_trig_mode = 1'b1;
    cfg_trig_lvl = 8'd4;
    for (int i = 0; i < 3; i++) send(8'(i + 1), 5, 0, 1, 0, 0);
    check("R8 below level", irq_rx_data, 0);
    send(8'h04, 5, 0, 1, 0, 0);
    check("R8 at level", irq_rx_data, 1);
    cfg_rx_ien = 1'b0;
    repeat (2) @(negedge clk);
    check("R8 gated off", irq_rx_data, 0);
    cfg_rx_ien = 1'b1;
    cfg_trig_mode = 1'b0;
    for (int i = 0; i < 3; i++) pop();
    repeat (2) @(negedge clk);
    check("R8 per char with one", irq_rx_data, 1);
    pop();
    repeat (2) @(negedge clk);
    check("R8 none when empty", irq_rx_data, 0);
  endtask

  task automatic t_timeout();
    // limit = 16*(4*5+12) ticks = 1024 clocks after the store
    cfg_wlen = 2'd0;
    cfg_rx_ien = 1'b1;
    send(8'h11, 5, 0, 1, 0, 0);
    repeat (900) @(negedge clk);
    check("R9 not yet", irq_rx_tmo, 0);
    repeat (150) @(negedge clk);
    check("R9 fires", irq_rx_tmo, 1);
    send(8'h12, 5, 0, 1, 0, 0);
    check("R9 cleared by arrival", irq_rx_tmo, 0);
    repeat (900) @(negedge clk);
    pop();
    repeat (900) @(negedge clk);
    check("R9 read restarts count", irq_rx_tmo, 0);
    repeat (200) @(negedge clk);
    check("R9 fires after restart", irq_rx_tmo, 1);
    pop();
    repeat (2) @(negedge clk);
    check("R9 empty clears", irq_rx_tmo, 0);
    cfg_rx_ien = 1'b0;
  endtask

  task automatic t_overrun();
    int bad;
    cfg_wlen = 2'd0;
    for (int i = 0; i < 128; i++) send(8'(i), 5, 0, 1, 0, 0);
    check("R5 full count", rx_fill, 128);
    check("R7 no overrun yet", lsr[1], 0);
    send(8'h1F, 5, 0, 1, 0, 0);
    check("R7 count held", rx_fill, 128);
    check("R7 overrun set", lsr[1], 1);
    check("R7 head unchanged", rd_data, 0);
    pop();
    check("R7 overrun cleared", lsr[1], 0);
    bad = 0;
    for (int i = 1; i < 128; i++) begin
      if (rd_data != 8'(i % 32)) bad++;
      pop();
    end
    check("R5 order kept", bad, 0);
    check("R7 dropped byte absent", rx_fill, 0);
  endtask

  task automatic t_coincide();
    int bad;
    cfg_wlen = 2'd0;
    for (int i = 0; i < 40; i++) send(8'(i % 32), 5, 0, 1, 0, 0);
    send(8'h1A, 5, 0, 1, 0, 1);
    bad = 0;
    for (int k = 0; k < BIT; k++) if (popped[k] != 8'(k)) bad++;
    check("R10 popped order", bad, 0);
    check("R10 fill after overlap", rx_fill, 9);
    bad = 0;
    for (int i = 32; i < 40; i++) begin
      if (rd_data != 8'(i % 32)) bad++;
      pop();
    end
    check("R10 remaining order", bad, 0);
    check("R10 new byte at tail", rd_data, 8'h1A);
    check("R10 new byte clean", lsr, 5'b00001);
    pop();
    check("R10 drained", rx_fill, 0);
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rst = 1'b0;
    repeat (2) @(negedge clk);
    t_reset();
    t_basic();
    t_wlen();
    t_false_start();
    t_parity();
    t_frame_break();
    t_trigger();
    t_timeout();
    t_overrun();
    t_coincide();
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog actual=running expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

endmodule